// File: doc/BRIEF.md
# Dual-Mode Add / Subtract-From Carry Unit

This block is an integer adder for a 64-bit datapath that keeps a carry flag. It performs four operations: plain addition, addition with the incoming carry flag, subtract-from (operand B minus operand A, formed as the inverse of A plus B plus one), and subtract-from that uses the incoming carry in place of the constant one. The arithmetic is combinational, and one register stage captures the result and the new carry flag, so both appear one clock after the operands.

A mode input picks between wide and narrow operation. The data result is the same in both modes: it is always the full 64-bit sum and is never truncated or zero-extended from a 32-bit sum. Only the carry flag changes with the mode. In wide mode it is the carry out of the top bit. In narrow mode it is the carry that reaches bit 32. Bits 63..32 of the operands therefore show up in the upper result bits but never affect the narrow carry. A carry-enable input lets the surrounding pipeline leave the flag alone: when it is low, the incoming carry value passes through unchanged.

Top module: `cy_addsub_unit`

## Requirements
- R1: While rst_n is low, result is 0 and carry_out is 0.
- R2: result and carry_out reflect the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: With op_sel = 2'b00 (plain add), result = op_a + op_b modulo 2^64, and carry_in is not added.
- R4: With op_sel = 2'b01 (add with carry), result = op_a + op_b + carry_in modulo 2^64.
- R5: With op_sel = 2'b10 (subtract-from), result = ~op_a + op_b + 1 modulo 2^64, which equals op_b - op_a.
- R6: With op_sel = 2'b11 (subtract-from with carry), result = ~op_a + op_b + carry_in modulo 2^64.
- R7: With narrow = 0 and carry_en = 1, carry_out is the carry out of bit 63, that is bit 64 of the 65-bit sum of the two adder inputs and the carry term.
- R8: The value of narrow has no effect on result. In narrow mode result still holds the full 64-bit sum, including the upper 32 bits.
- R9: With narrow = 1 and carry_en = 1, carry_out is the carry into bit 32, which is bit 32 of (sum XOR adder input X XOR adder input Y). Operand bits 63..32 do not affect it.
- R10: With carry_en = 0, carry_out equals carry_in and result is computed as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 64 | Operand A (inverted for subtract-from) |
| op_b | input | 64 | Operand B |
| carry_in | input | 1 | Current carry flag |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 subtract-from, 11 subtract-from with carry |
| narrow | input | 1 | 1 takes the carry from the 32-bit boundary, 0 from bit 63 |
| carry_en | input | 1 | 1 updates the carry flag, 0 passes carry_in through |
| result | output | 64 | Registered 64-bit result |
| carry_out | output | 1 | Registered new carry flag |

## Verification
A wrong internal value becomes visible at the ports one clock after the operands that expose it, because only one register lies between the inputs and the outputs. Three kinds of fault matter most. A narrow-mode path that truncates shows up as zeroed upper result bits. A carry tap at the wrong position shows up as a carry that follows upper-half operand bits. A misrouted carry-in shows up as an off-by-one result only in the with-carry operations. The stimulus mixes random operands, some with low halves set equal or to all ones, with directed vectors such as 0x1_FFFFFFFF plus 1 and subtract-from with equal low halves, so that each of these faults changes an observed bit.

// File: rtl/cy_addsub_pkg.sv
package cy_addsub_pkg;

    // Bit 1 selects inversion of operand A, bit 0 selects the carry flag as carry term
    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_ADDC  = 2'b01,
        OP_SUBF  = 2'b10,
        OP_SUBFC = 2'b11
    } arith_op_e;

    localparam int unsigned DATA_W = 64;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              carry;
    } arith_state_t;

endpackage

// File: rtl/cy_operand_prep.sv
// Forms the two adder inputs and the carry term from the operation select.
module cy_operand_prep #(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             flag_i,
    input  logic [1:0]       op_i,
    output logic [WIDTH-1:0] x_o,
    output logic [WIDTH-1:0] y_o,
    output logic             cin_o
);
    import cy_addsub_pkg::*;

    arith_op_e op;

    always_comb begin
        op    = arith_op_e'(op_i);
        x_o   = a_i;
        y_o   = b_i;
        cin_o = 1'b0;
        unique case (op)
            OP_ADD:   begin x_o = a_i;  cin_o = 1'b0;   end
            OP_ADDC:  begin x_o = a_i;  cin_o = flag_i; end
            OP_SUBF:  begin x_o = ~a_i; cin_o = 1'b1;   end
            OP_SUBFC: begin x_o = ~a_i; cin_o = flag_i; end
            default:  begin x_o = a_i;  cin_o = 1'b0;   end
        endcase
    end
endmodule

// File: rtl/cy_adder_core.sv
// Full-width adder; returns the sum, the carry out of the top bit and the
// carry that reaches bit position TAP.
module cy_adder_core #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned TAP   = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_top_o,
    output logic             carry_tap_o
);
    localparam int unsigned EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] wide_sum;

    always_comb begin
        wide_sum    = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
        sum_o       = wide_sum[WIDTH-1:0];
        carry_top_o = wide_sum[WIDTH];
        // a sum bit differing from the carry-less sum bit means a carry arrived
        carry_tap_o = wide_sum[TAP] ^ x_i[TAP] ^ y_i[TAP];
    end
endmodule

// File: rtl/cy_carry_select.sv
// Picks the new carry flag from the mode and the update enable.
module cy_carry_select (
    input  logic narrow_i,
    input  logic enable_i,
    input  logic flag_i,
    input  logic carry_top_i,
    input  logic carry_tap_i,
    output logic carry_o
);
    always_comb begin
        if (!enable_i) begin
            carry_o = flag_i;
        end else if (narrow_i) begin
            carry_o = carry_tap_i;
        end else begin
            carry_o = carry_top_i;
        end
    end
endmodule

// File: rtl/cy_addsub_unit.sv
module cy_addsub_unit #(
    parameter int unsigned WIDTH    = 64,
    parameter int unsigned NARROW_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [1:0]       op_sel,
    input  logic             narrow,
    input  logic             carry_en,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);
    localparam int unsigned TAP_POS = NARROW_W;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             carry;
    } unit_state_t;

    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_ctop;
    logic             add_ctap;
    logic             new_carry;

    unit_state_t state_d;
    unit_state_t state_q;

    generate
        if (NARROW_W >= WIDTH || NARROW_W == 0) begin : g_bad_width
            initial $error("NARROW_W must be between 1 and WIDTH-1");
        end
    endgenerate

    cy_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .a_i    (op_a),
        .b_i    (op_b),
        .flag_i (carry_in),
        .op_i   (op_sel),
        .x_o    (add_x),
        .y_o    (add_y),
        .cin_o  (add_cin)
    );

    cy_adder_core #(.WIDTH(WIDTH), .TAP(TAP_POS)) u_core (
        .x_i         (add_x),
        .y_i         (add_y),
        .cin_i       (add_cin),
        .sum_o       (add_sum),
        .carry_top_o (add_ctop),
        .carry_tap_o (add_ctap)
    );

    cy_carry_select u_csel (
        .narrow_i    (narrow),
        .enable_i    (carry_en),
        .flag_i      (carry_in),
        .carry_top_i (add_ctop),
        .carry_tap_i (add_ctap),
        .carry_o     (new_carry)
    );

    always_comb begin
        state_d        = state_q;
        state_d.result = add_sum;
        state_d.carry  = new_carry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result    = state_q.result;
    assign carry_out = state_q.carry;
endmodule

// File: rtl/cy_addsub_chk.sv
module cy_addsub_chk #(
    parameter int unsigned WIDTH    = 64,
    parameter int unsigned NARROW_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [1:0]       op_sel,
    input logic             narrow,
    input logic             carry_en,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);
    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && carry_out == 1'b0));

    // R3
    plain_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 2'b00) |-> result == $past(op_a) + $past(op_b));

    // R5
    subf_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(op_sel) == 2'b10) |-> result == $past(op_b) - $past(op_a));

    // R10
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(carry_en)) |-> carry_out == $past(carry_in));

    // R7
    wide_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(carry_en) && !$past(narrow) && $past(op_sel) == 2'b00)
        |-> carry_out == (({1'b0, $past(op_a)} + {1'b0, $past(op_b)}) >> WIDTH));

    // R9
    narrow_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(carry_en) && $past(narrow) && $past(op_sel) == 2'b00)
        |-> carry_out == ((({1'b0, $past(op_a[NARROW_W-1:0])}
                          + {1'b0, $past(op_b[NARROW_W-1:0])}) >> NARROW_W) != 0));
endmodule

bind cy_addsub_unit cy_addsub_chk #(.WIDTH(WIDTH), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/cy_addsub_unit_test.sv
`timescale 1ns/1ps
module cy_addsub_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic        narrow = 1'b0;
    logic        carry_en = 1'b0;
    logic [63:0] result;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cy_addsub_unit uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .op_sel(op_sel), .narrow(narrow),
        .carry_en(carry_en), .result(result), .carry_out(carry_out)
    );

    // Reference result from the operation definitions
    function automatic logic [63:0] ref_result(logic [63:0] a, logic [63:0] b,
                                                logic c, logic [1:0] op);
        case (op)
            2'b00:   return a + b;
            2'b01:   return a + b + {63'd0, c};
            2'b10:   return b - a;
            default: return b - a - 64'd1 + {63'd0, c};
        endcase
    endfunction

    // Reference carry: low-half sum for narrow mode, 65-bit sum for wide mode
    function automatic logic ref_carry(logic [63:0] a, logic [63:0] b, logic c,
                                       logic [1:0] op, logic nar, logic en);
        logic [63:0] x;
        logic        k;
        logic [64:0] full;
        logic [32:0] low;
        if (!en) return c;
        x    = op[1] ? ~a : a;
        k    = (op == 2'b10) ? 1'b1 : (op[0] ? c : 1'b0);
        full = {1'b0, x} + {1'b0, b} + {64'd0, k};
        low  = {1'b0, x[31:0]} + {1'b0, b[31:0]} + {32'd0, k};
        return nar ? low[32] : full[64];
    endfunction

    task automatic check64(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic string op_tag(logic [1:0] op);
        case (op)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    // Drive at falling edge, capture at rising edge, sample at next falling edge (R2)
    task automatic run_vec(logic [63:0] a, logic [63:0] b, logic c,
                           logic [1:0] op, logic nar, logic en);
        logic [63:0] er;
        logic        ec;
        string       ctag;
        op_a = a; op_b = b; carry_in = c; op_sel = op; narrow = nar; carry_en = en;
        er = ref_result(a, b, c, op);
        ec = ref_carry(a, b, c, op, nar, en);
        @(negedge clk);
        check64(nar ? "R8" : op_tag(op), result, er);
        ctag = !en ? "R10" : (nar ? "R9" : "R7");
        check64(ctag, {63'd0, carry_out}, {63'd0, ec});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: outputs cleared during reset
        check64("R1", result, 64'd0);
        check64("R1", {63'd0, carry_out}, 64'd0);
        op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h1; carry_en = 1'b1;
        @(negedge clk);
        check64("R1", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9, R8: upper bits nonzero, low half carries into bit 32
        run_vec(64'h0000_0001_FFFF_FFFF, 64'h1, 1'b0, 2'b00, 1'b1, 1'b1);
        check64("R8", result, 64'h0000_0002_0000_0000);
        check64("R9", {63'd0, carry_out}, 64'd1);
        // R7: same operands in wide mode give no carry out of bit 63
        run_vec(64'h0000_0001_FFFF_FFFF, 64'h1, 1'b0, 2'b00, 1'b0, 1'b1);
        check64("R7", {63'd0, carry_out}, 64'd0);
        // R7: all ones plus one carries out of the top
        run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 2'b00, 1'b0, 1'b1);
        check64("R7", {63'd0, carry_out}, 64'd1);
        check64("R3", result, 64'd0);
        // R9: upper bits overflow but low half does not
        run_vec(64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_0000_0001, 1'b0, 2'b00, 1'b1, 1'b1);
        check64("R9", {63'd0, carry_out}, 64'd0);
        // R5, R9: subtract-from with equal low halves
        run_vec(64'h0000_0005_1234_5678, 64'h0000_0009_1234_5678, 1'b0, 2'b10, 1'b1, 1'b1);
        check64("R5", result, 64'h0000_0004_0000_0000);
        check64("R9", {63'd0, carry_out}, 64'd1);
        // R6: subtract-from with carry clear is b - a - 1
        run_vec(64'd10, 64'd30, 1'b0, 2'b11, 1'b0, 1'b1);
        check64("R6", result, 64'd19);
        // R4 and R3: carry_in added only with carry ops
        run_vec(64'd7, 64'd8, 1'b1, 2'b01, 1'b0, 1'b1);
        check64("R4", result, 64'd16);
        run_vec(64'd7, 64'd8, 1'b1, 2'b00, 1'b0, 1'b1);
        check64("R3", result, 64'd15);
        // R10: carry held with enable low, result still computed
        run_vec(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 2'b00, 1'b0, 1'b0);
        check64("R10", {63'd0, carry_out}, 64'd0);
        run_vec(64'h1, 64'h1, 1'b1, 2'b10, 1'b1, 1'b0);
        check64("R10", {63'd0, carry_out}, 64'd1);

        for (int i = 0; i < 600; i++) begin
            logic [63:0] a;
            logic [63:0] b;
            int          shape;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            shape = int'($urandom % 4);
            if (shape == 1) b[31:0] = a[31:0];
            if (shape == 2) a[31:0] = 32'hFFFF_FFFF;
            if (shape == 3) b[31:0] = ~a[31:0];
            run_vec(a, b, 1'($urandom), 2'($urandom), 1'($urandom), ($urandom % 5) != 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule